// File: doc/BRIEF.md
# Synchronous Transmitter with Automatic Sync Fill

This block is a character-oriented synchronous serial transmitter. The CPU writes 5 to 8 bit characters into a holding register. At each character boundary the holding register is copied into a separate shift register. The character then leaves on `txd`, least significant bit first, one bit per transmit-clock strobe. The strobe is a one-cycle pulse that marks the falling edge of the transmit clock.

A message begins when the first written character is loaded. If the holding register is still empty at a later boundary, and transmission is enabled, the block fills the gap with the programmed sync character. In double-sync mode it fills with the pair of sync characters instead, so the line never idles in the middle of a message.

Clearing the enable bit does not cut off data that has already been written. When the message ends the line goes to mark, unless a break is being forced.

Top module: `sync_fill_tx`

## Requirements
- R1: `len_sel` selects the character length: 0 → 5 bits, 1 → 6, 2 → 7, 3 → 8. Every character, data or sync, occupies exactly that many strobes. Bits above the length are never sent.
- R2: Bits leave LSB first. `txd` changes only in the clock cycle that carries a `bit_stb` pulse and shows the new bit after that edge.
- R3: A write is accepted only while the holding register is empty. A write made while it is full is ignored. The held character moves to the shift register at the next character boundary.
- R4: At a boundary inside a running message, if the holding register is empty and `tx_en` is 1, the sync character `sync_a` is sent. Fill never starts a message from idle.
- R5: With `dual_sync` set, a fill sends `sync_a` and then `sync_b`. The pair is never split, even by data written after `sync_a` has started; that data goes out after `sync_b`.
- R6: Clearing `tx_en` does not stop a character in flight or a character already in the holding register. Both are sent in full.
- R7: When a boundary finds no data, no pending second sync, and either `tx_en` low or no running message, the block goes idle and `txd` is 1.
- R8: While `brk` is 1, `txd` is 0 regardless of state. When `brk` clears, `txd` shows the normal bit again.
- R9: `tx_rdy` is 1 exactly when the holding register is empty and `tx_en` is 1.
- R10: `tx_empty` is 1 when the holding register is empty and the shift register holds no data character. Sync fill counts as empty.
- R11: After reset `txd` is 1, the holding register is empty and the transmitter is idle.
- R12: A write in the same cycle as a boundary strobe is stored in the holding register. The loader acts on the holding state before that write, so it sends sync and the written data follows as the next character.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_stb | input | 1 | One-cycle pulse marking a transmit-clock falling edge |
| wr_en | input | 1 | Write strobe into the holding register |
| wr_data | input | CW | Character to transmit |
| len_sel | input | 2 | Character length code (5 + value bits) |
| dual_sync | input | 1 | 1 selects a two-character sync fill |
| sync_a | input | CW | First (or only) sync character |
| sync_b | input | CW | Second sync character |
| tx_en | input | 1 | Transmit enable command |
| brk | input | 1 | Forces the line low |
| txd | output | 1 | Serial data out |
| tx_rdy | output | 1 | Holding register empty and transmit enabled |
| tx_empty | output | 1 | No data character held or shifting |

## Verification
Two functions can coincide in one cycle. The first is a CPU write landing on the very strobe that closes a character; the bench drives `wr_en` and `bit_stb` together at that boundary, then checks that a sync character goes out first and the written character follows it intact. The second is a forced break during a character; the bench raises `brk` mid-character, checks that the line is low, and after release checks that the pending bit and the rest of the character are unchanged.

// File: rtl/sync_fill_tx.sv
module sync_fill_tx #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_stb,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_data,
  input  logic [1:0]    len_sel,
  input  logic          dual_sync,
  input  logic [CW-1:0] sync_a,
  input  logic [CW-1:0] sync_b,
  input  logic          tx_en,
  input  logic          brk,
  output logic          txd,
  output logic          tx_rdy,
  output logic          tx_empty
);
  localparam int NW = $clog2(CW);

  logic [CW-1:0] hold, shreg, nxt;
  logic          hold_full, active, data_sh, sph, txd_q;
  logic [NW-1:0] cnt, last_idx;
  logic          boundary, start_char;

  assign last_idx   = NW'(4) + NW'(len_sel);
  assign boundary   = !active || (cnt == '0);
  assign nxt        = sph ? sync_b : (hold_full ? hold : sync_a);
  assign start_char = sph || hold_full || (tx_en && active);

  assign txd      = brk ? 1'b0 : txd_q;
  assign tx_rdy   = !hold_full && tx_en;
  assign tx_empty = !hold_full && !data_sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold      <= '0;
      hold_full <= 1'b0;
      shreg     <= '0;
      cnt       <= '0;
      active    <= 1'b0;
      data_sh   <= 1'b0;
      sph       <= 1'b0;
      txd_q     <= 1'b1;
    end else begin
      if (wr_en && !hold_full) begin
        hold      <= wr_data;
        hold_full <= 1'b1;
      end
      if (bit_stb) begin
        if (!boundary) begin
          txd_q <= shreg[0];
          shreg <= shreg >> 1;
          cnt   <= cnt - 1'b1;
        end else if (start_char) begin
          txd_q   <= nxt[0];
          shreg   <= nxt >> 1;
          cnt     <= last_idx;
          active  <= 1'b1;
          data_sh <= !sph && hold_full;
          if (sph)
            sph <= 1'b0;
          else if (hold_full)
            hold_full <= 1'b0;
          else
            sph <= dual_sync;
        end else begin
          active  <= 1'b0;
          data_sh <= 1'b0;
          txd_q   <= 1'b1;
        end
      end
    end
  end

  AST_IDLE_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !brk) |-> txd); // R7
  AST_NO_MIDCHAR_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && active && cnt != '0) |=> active); // R6
  AST_SYNC_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_stb && active && cnt == '0 && sph) |=> (active && !data_sh && !sph)); // R5
  AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (hold_full && !(bit_stb && boundary && !sph)) |=> hold_full); // R3
endmodule

// File: tb/sync_fill_tx_bench.sv
`timescale 1ns/1ps
module sync_fill_tx_bench;
  logic clk = 1'b0, rst_n = 1'b0, bit_stb = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0, sync_a = 8'h16, sync_b = 8'h2B;
  logic [1:0] len_sel = 2'd3;
  logic dual_sync = 1'b0, tx_en = 1'b0, brk = 1'b0;
  logic txd, tx_rdy, tx_empty;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  sync_fill_tx #(.CW(8)) u_sync_fill_tx (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .wr_en(wr_en), .wr_data(wr_data),
    .len_sel(len_sel), .dual_sync(dual_sync), .sync_a(sync_a), .sync_b(sync_b),
    .tx_en(tx_en), .brk(brk), .txd(txd), .tx_rdy(tx_rdy), .tx_empty(tx_empty));

  // fields: len code, data, tx_en
  localparam logic [10:0] VEC [7] = '{
    {2'd0, 8'h15, 1'b1}, {2'd1, 8'h2C, 1'b1}, {2'd2, 8'h5A, 1'b1},
    {2'd3, 8'hC3, 1'b1}, {2'd3, 8'h81, 1'b0}, {2'd0, 8'hEE, 1'b0},
    {2'd2, 8'hFF, 1'b1}};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic strobe();
    bit_stb = 1'b1;
    @(negedge clk);
    bit_stb = 1'b0;
  endtask

  task automatic write(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic get_bits(input int n, output logic [7:0] v);
    v = '0;
    for (int i = 0; i < n; i++) begin
      strobe();
      v[i] = txd;
    end
  endtask

  function automatic logic [7:0] mask(input logic [7:0] d, input int n);
    return d & 8'((1 << n) - 1);
  endfunction

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] v, b0;
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 txd", {7'd0, txd}, 8'd1);
    chk("R11 tx_empty", {7'd0, tx_empty}, 8'd1);
    chk("R9 rdy disabled", {7'd0, tx_rdy}, 8'd0);
    tx_en = 1'b1;
    @(negedge clk);
    chk("R9 rdy enabled", {7'd0, tx_rdy}, 8'd1);
    strobe(); strobe();
    chk("R7 no fill from idle", {7'd0, txd}, 8'd1);

    // R1 R2 R6 R7: table of length / data / enable
    foreach (VEC[k]) begin
      len_sel = VEC[k][10:9];
      tx_en   = VEC[k][0];
      n = 5 + int'(VEC[k][10:9]);
      write(VEC[k][8:1]);
      get_bits(n, v);
      chk("R1 R2 R6 char", v, mask(VEC[k][8:1], n));
      tx_en = 1'b0;
      strobe();
      chk("R7 mark after end", {7'd0, txd}, 8'd1);
    end

    // R3 R4 R10: double buffering and single sync fill
    len_sel = 2'd3; tx_en = 1'b1; dual_sync = 1'b0;
    write(8'h3C);
    chk("R9 rdy full", {7'd0, tx_rdy}, 8'd0);
    chk("R10 empty held", {7'd0, tx_empty}, 8'd0);
    get_bits(1, b0);
    chk("R3 rdy after load", {7'd0, tx_rdy}, 8'd1);
    write(8'h96);
    write(8'hFF);
    chk("R3 rdy after second write", {7'd0, tx_rdy}, 8'd0);
    get_bits(7, v);
    chk("R3 first char", {v[6:0], b0[0]}, 8'h3C);
    get_bits(1, b0);
    chk("R10 empty during data", {7'd0, tx_empty}, 8'd0);
    get_bits(7, v);
    chk("R3 second char not overwritten", {v[6:0], b0[0]}, 8'h96);
    get_bits(1, b0);
    chk("R10 empty during sync", {7'd0, tx_empty}, 8'd1);
    get_bits(7, v);
    chk("R4 sync fill", {v[6:0], b0[0]}, 8'h16);
    tx_en = 1'b0;
    strobe();
    chk("R7 mark after fill", {7'd0, txd}, 8'd1);

    // R5: dual sync pair not split by late data
    tx_en = 1'b1; dual_sync = 1'b1;
    write(8'h55);
    get_bits(8, v);
    chk("R5 data before fill", v, 8'h55);
    get_bits(1, b0);
    write(8'hE1);
    get_bits(7, v);
    chk("R5 sync_a first", {v[6:0], b0[0]}, 8'h16);
    get_bits(8, v);
    chk("R5 sync_b second", v, 8'h2B);
    get_bits(8, v);
    chk("R5 data after pair", v, 8'hE1);
    tx_en = 1'b0; dual_sync = 1'b0;
    strobe();
    chk("R7 mark after pair", {7'd0, txd}, 8'd1);

    // R6: disable while a char shifts and another is held
    tx_en = 1'b1; len_sel = 2'd1;
    write(8'h2D);
    get_bits(1, b0);
    write(8'h13);
    tx_en = 1'b0;
    get_bits(5, v);
    chk("R6 char in flight", {2'b0, v[4:0], b0[0]}, 8'h2D);
    get_bits(6, v);
    chk("R6 held char sent", v, 8'h13);
    chk("R9 rdy low when disabled", {7'd0, tx_rdy}, 8'd0);
    strobe();
    chk("R7 mark", {7'd0, txd}, 8'd1);
    chk("R10 empty at idle", {7'd0, tx_empty}, 8'd1);

    // R8: break idle and mid-character
    brk = 1'b1;
    @(negedge clk);
    chk("R8 break idle", {7'd0, txd}, 8'd0);
    brk = 1'b0;
    @(negedge clk);
    chk("R8 release idle", {7'd0, txd}, 8'd1);
    len_sel = 2'd3;
    write(8'hA7);
    get_bits(1, b0);
    brk = 1'b1;
    @(negedge clk);
    chk("R8 break mid-char", {7'd0, txd}, 8'd0);
    brk = 1'b0;
    @(negedge clk);
    chk("R8 bit restored", {7'd0, txd}, 8'd1);
    get_bits(7, v);
    chk("R8 char intact", {v[6:0], b0[0]}, 8'hA7);
    strobe();

    // R12: write on the boundary strobe
    tx_en = 1'b1; len_sel = 2'd0;
    write(8'h09);
    get_bits(5, v);
    chk("R12 lead char", v, 8'h09);
    wr_en = 1'b1; wr_data = 8'h1A; bit_stb = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; bit_stb = 1'b0;
    b0 = {7'd0, txd};
    get_bits(4, v);
    chk("R12 sync chosen", {3'b0, v[3:0], b0[0]}, 8'h16);
    get_bits(5, v);
    chk("R12 written data follows", v, 8'h1A);
    tx_en = 1'b0;
    strobe();
    chk("R7 final mark", {7'd0, txd}, 8'd1);

    summary();
    $finish;
  end
endmodule